// File: doc/BRIEF.md
# Banked GPIO Port with Pin Interrupt Detection

This block is one bank of general-purpose pins with a flat register file. Software sets each pin's direction, output value and alternate-function select; these drive the pad-side outputs `pin_oe`, `pin_out` and `alt_sel` directly. The block samples the input pins through a synchronizer. Software reads the synchronized levels from a read-only register. A wider port is built by placing several instances side by side.

Every pin has its own interrupt detector. One trigger-type bit chooses between edge and level detection. An edge-polarity bit chooses a rising or falling edge, and a separate level-polarity bit chooses active high or active low. A detected condition sets a sticky status bit, whether or not the pin is masked. The bank interrupt is the OR of the status bits whose mask bit is 0, so a mask bit of 1 blocks its pin. To catch both edges, software reads the pin level, programs the opposite edge, and flips the edge-polarity bit after each event.

Register addresses on `reg_addr`: 0 direction, 1 output data, 2 pin levels (read only), 3 alternate function, 4 interrupt mask, 5 trigger type, 6 edge polarity, 7 level polarity, 8 interrupt status. Bit n of every register belongs to pin n.

Top module: `gpio_irq_bank`

## Requirements
- R1: During and after reset: direction, output, alternate-function and status read 0; mask, trigger type and edge polarity read all ones; level polarity reads 0; `irq` is low. With all pins low, no status bit sets after reset.
- R2: Writes to address 0, 1 and 3 appear on `pin_oe` (1 = output), `pin_out` and `alt_sel` on the next clock, and read back at the same address.
- R3: Address 2 returns `pin_in` delayed by SYNC_STAGES clocks (2 by default), and does not show it earlier.
- R4: With trigger type 1 (edge) and edge polarity 1, a low-to-high pin change sets the pin's status bit, and a high-to-low change does not.
- R5: With trigger type 1 and edge polarity 0, a high-to-low change sets the status bit. Flipping the edge polarity after each event catches both edges.
- R6: With trigger type 0 (level), the status bit sets while the pin is high (level polarity 1) or low (level polarity 0). It sets again right after a clear while that level holds.
- R7: Status bits are sticky. Writing address 8 clears each bit written 0 and keeps each bit written 1.
- R8: A status bit sets even when its mask bit is 1. `irq` is high exactly when some status bit has mask bit 0. With an all-ones mask, `irq` stays low.
- R9: When a status write clears a bit in the same clock as a new event for that bit, the bit ends up set.
- R10: Writes to address 2 and to unmapped addresses (9 to 15) change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data register |
| pin_oe | output | 16 | Direction register, 1 = drive the pin |
| alt_sel | output | 16 | Alternate-function select register |
| irq | output | 1 | Bank interrupt request |

## Verification
A stale edge-history flop shows up as a status bit that sets on the wrong transition, or does not set at all. This is visible at address 8 three clocks after the pin moves. A wrong status update shows up in the clock after the write: a bit that should stay set reads 0, or a cleared bit comes back. A cleared bit that comes back also moves `irq` in that same cycle, because `irq` is combinational from status and mask. Synchronizer depth errors show up as the pin-level register updating one cycle early or late. The bench checks that register on both sides of the expected cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [3:0] {
      REG_DIR  = 4'd0,
      REG_OUT  = 4'd1,
      REG_PINS = 4'd2,
      REG_ALT  = 4'd3,
      REG_MASK = 4'd4,
      REG_TRIG = 4'd5,
      REG_EPOL = 4'd6,
      REG_LPOL = 4'd7,
      REG_STAT = 4'd8
   } bank_reg_e;

   localparam int unsigned BANK_REG_COUNT = 9;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] trig_edge,
   input  logic [WIDTH-1:0] edge_rise,
   input  logic [WIDTH-1:0] level_high,
   output logic [WIDTH-1:0] evt
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise_w;
   logic [WIDTH-1:0] fall_w;
   logic [WIDTH-1:0] edge_hit;
   logic [WIDTH-1:0] lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   always_comb begin
      rise_w   = level & ~prev_q;
      fall_w   = ~level & prev_q;
      edge_hit = (edge_rise & rise_w) | (~edge_rise & fall_w);
      lvl_hit  = (level_high & level) | (~level_high & ~level);
      evt      = (trig_edge & edge_hit) | (~trig_edge & lvl_hit);
   end

endmodule

// File: rtl/gpio_stat_latch.sv
module gpio_stat_latch #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] clr_keep,
   output logic [WIDTH-1:0] stat
);

   logic [WIDTH-1:0] stat_q;
   logic [WIDTH-1:0] kept_w;

   assign kept_w = clr_wr ? (stat_q & clr_keep) : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= kept_w | evt;
   end

   assign stat = stat_q;

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((stat_q & $past(evt)) == $past(evt))); // R9

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH          = 16,
   parameter int ADDR_W         = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WIDTH-1:0]  reg_wdata,
   output logic [WIDTH-1:0]  reg_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  alt_sel,
   output logic              irq
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam int MIN_ADDR_W = $clog2(BANK_REG_COUNT);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W too small for the register map");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_irq_bank: WIDTH must be positive");
   end

   logic [WIDTH-1:0] dir_q, out_q, alt_q, mask_q, trig_q, epol_q, lpol_q;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] evt_w;
   logic [WIDTH-1:0] stat_w;
   logic             stat_wr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input bank_reg_e r);
      return a == ADDR_W'(r);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         alt_q  <= '0;
         mask_q <= ALL_ONES;
         trig_q <= ALL_ONES;
         epol_q <= ALL_ONES;
         lpol_q <= '0;
      end else if (reg_wr) begin
         if (hit(reg_addr, REG_DIR))  dir_q  <= reg_wdata;
         if (hit(reg_addr, REG_OUT))  out_q  <= reg_wdata;
         if (hit(reg_addr, REG_ALT))  alt_q  <= reg_wdata;
         if (hit(reg_addr, REG_MASK)) mask_q <= reg_wdata;
         if (hit(reg_addr, REG_TRIG)) trig_q <= reg_wdata;
         if (hit(reg_addr, REG_EPOL)) epol_q <= reg_wdata;
         if (hit(reg_addr, REG_LPOL)) lpol_q <= reg_wdata;
      end
   end

   assign stat_wr = reg_wr && hit(reg_addr, REG_STAT);

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pins_sync)
   );

   gpio_evt_detect #(.WIDTH(WIDTH)) i_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (pins_sync),
      .trig_edge  (trig_q),
      .edge_rise  (epol_q),
      .level_high (lpol_q),
      .evt        (evt_w)
   );

   gpio_stat_latch #(.WIDTH(WIDTH)) i_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_w),
      .clr_wr   (stat_wr),
      .clr_keep (reg_wdata),
      .stat     (stat_w)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(REG_DIR):  reg_rdata = dir_q;
         ADDR_W'(REG_OUT):  reg_rdata = out_q;
         ADDR_W'(REG_PINS): reg_rdata = pins_sync;
         ADDR_W'(REG_ALT):  reg_rdata = alt_q;
         ADDR_W'(REG_MASK): reg_rdata = mask_q;
         ADDR_W'(REG_TRIG): reg_rdata = trig_q;
         ADDR_W'(REG_EPOL): reg_rdata = epol_q;
         ADDR_W'(REG_LPOL): reg_rdata = lpol_q;
         ADDR_W'(REG_STAT): reg_rdata = stat_w;
         default:           reg_rdata = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign alt_sel = alt_q;

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(stat_w & ~mask_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(stat_w & ~mask_q);

      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q == ALL_ONES) |-> !irq); // R8
   end

   AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hit(reg_addr, REG_DIR)) |=> (pin_oe == $past(reg_wdata))); // R2

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (mask_q == ALL_ONES && dir_q == '0 && stat_w == '0)); // R1

endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [3:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic [15:0] pin_in;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic [15:0] alt_sel;
   logic        irq;

   always #2.5 clk = ~clk;

   gpio_irq_bank i_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
   );

   typedef struct {
      int          kind;
      logic [15:0] exp;
      string       req;
   } item_t;

   localparam int K_RDATA = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3, K_ALT = 4;
   localparam logic [3:0] A_DIR = 0, A_OUT = 1, A_PINS = 2, A_ALT = 3, A_MASK = 4,
                          A_TRIG = 5, A_EPOL = 6, A_LPOL = 7, A_STAT = 8;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // monitor: pops expected items and compares them 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t       it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
               K_RDATA: act = reg_rdata;
               K_IRQ:   act = {15'b0, irq};
               K_OUT:   act = pin_out;
               K_OE:    act = pin_oe;
               default: act = alt_sel;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [15:0] exp, input string req);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      q.push_back(it);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic expect_reg(input logic [3:0] a, input logic [15:0] exp, input string req);
      reg_addr = a;
      push(K_RDATA, exp, req);
      @(negedge clk);
   endtask

   task automatic expect_sig(input int kind, input logic [15:0] exp, input string req);
      push(kind, exp, req);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
      idle(3);
      // R1 values held during reset
      expect_reg(A_DIR,  16'h0000, "R1 dir reset");
      expect_reg(A_MASK, 16'hffff, "R1 mask reset");
      expect_reg(A_TRIG, 16'hffff, "R1 trig reset");
      expect_reg(A_EPOL, 16'hffff, "R1 edge pol reset");
      expect_reg(A_LPOL, 16'h0000, "R1 level pol reset");
      expect_reg(A_ALT,  16'h0000, "R1 alt reset");
      expect_sig(K_IRQ,  16'h0000, "R1 irq reset");
      rst_n = 1'b1;
      idle(4);
      expect_reg(A_STAT, 16'h0000, "R1 no status after reset");

      // R2 pad-side registers
      wr(A_DIR, 16'ha5c3);
      expect_sig(K_OE, 16'ha5c3, "R2 pin_oe");
      expect_reg(A_DIR, 16'ha5c3, "R2 dir readback");
      wr(A_OUT, 16'h1234);
      expect_sig(K_OUT, 16'h1234, "R2 pin_out");
      wr(A_ALT, 16'h0f0f);
      expect_sig(K_ALT, 16'h0f0f, "R2 alt_sel");
      expect_reg(A_ALT, 16'h0f0f, "R2 alt readback");

      // R10 ignored writes
      wr(A_PINS, 16'hffff);
      wr(4'hc, 16'h1111);
      expect_reg(A_PINS, 16'h0000, "R10 pin register not writable");
      expect_reg(A_DIR, 16'ha5c3, "R10 dir untouched");
      expect_reg(4'hc, 16'h0000, "R10 unmapped reads 0");

      // R3 synchronizer latency; R4 rising edge while masked
      pin_in = 16'h8001;
      idle(1);
      expect_reg(A_PINS, 16'h0000, "R3 not visible after one clock");
      expect_reg(A_PINS, 16'h8001, "R3 visible after two clocks");
      expect_reg(A_STAT, 16'h8001, "R4 rising sets status");
      expect_sig(K_IRQ, 16'h0000, "R8 masked status keeps irq low");
      wr(A_MASK, 16'hfffe);
      expect_sig(K_IRQ, 16'h0001, "R8 unmask raises irq");
      wr(A_STAT, 16'h0000);
      expect_reg(A_STAT, 16'h0000, "R7 write 0 clears");
      expect_sig(K_IRQ, 16'h0000, "R8 irq drops with status");

      pin_in = 16'h0000;
      idle(4);
      expect_reg(A_STAT, 16'h0000, "R4 falling ignored in rising mode");
      pin_in = 16'h0003;
      idle(4);
      expect_reg(A_STAT, 16'h0003, "R4 two rising edges");
      wr(A_STAT, 16'hfffe);
      expect_reg(A_STAT, 16'h0002, "R7 write 1 keeps bit");
      expect_sig(K_IRQ, 16'h0000, "R8 only masked bit left");

      // R5 falling edge
      wr(A_EPOL, 16'h0000);
      wr(A_STAT, 16'h0000);
      pin_in = 16'h0000;
      idle(4);
      expect_reg(A_STAT, 16'h0003, "R5 falling sets status");
      expect_sig(K_IRQ, 16'h0001, "R8 unmasked falling raises irq");

      // R5 both-edge emulation on pin 4
      wr(A_STAT, 16'h0000);
      expect_reg(A_PINS, 16'h0000, "R5 pin 4 starts low");
      wr(A_EPOL, 16'h0010);
      pin_in = 16'h0010;
      idle(4);
      expect_reg(A_STAT, 16'h0010, "R5 emulated rising");
      wr(A_STAT, 16'h0000);
      wr(A_EPOL, 16'h0000);
      pin_in = 16'h0000;
      idle(4);
      expect_reg(A_STAT, 16'h0010, "R5 emulated falling");

      // R6 level detection on pin 3
      wr(A_STAT, 16'h0000);
      wr(A_LPOL, 16'h0008);
      wr(A_TRIG, 16'hfff7);
      idle(2);
      expect_reg(A_STAT, 16'h0000, "R6 low pin, active high");
      pin_in = 16'h0008;
      idle(4);
      expect_reg(A_STAT, 16'h0008, "R6 active high sets");
      wr(A_STAT, 16'h0000);
      expect_reg(A_STAT, 16'h0008, "R6 resets while level holds");
      pin_in = 16'h0000;
      idle(4);
      wr(A_STAT, 16'h0000);
      expect_reg(A_STAT, 16'h0000, "R6 clear sticks once level gone");
      wr(A_LPOL, 16'h0000);
      idle(2);
      expect_reg(A_STAT, 16'h0008, "R6 active low sets");

      // R9 clear and event in the same clock
      wr(A_TRIG, 16'hffff);
      wr(A_EPOL, 16'hffff);
      idle(4);
      wr(A_STAT, 16'h0000);
      expect_reg(A_STAT, 16'h0000, "R9 setup cleared");
      pin_in = 16'h0040;
      idle(4);
      expect_reg(A_STAT, 16'h0040, "R9 setup bit 6");
      pin_in = 16'h0060;
      idle(2);
      wr(A_STAT, 16'h0000);
      expect_reg(A_STAT, 16'h0020, "R9 event wins over clear");

      wr(A_MASK, 16'hffff);
      expect_sig(K_IRQ, 16'h0000, "R8 all masked");
      expect_reg(A_STAT, 16'h0020, "R8 status kept under mask");

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule